// File: doc/BRIEF.md
# Paged Processor Register Port

This block connects an 8-bit asynchronous microprocessor bus to a time-slot switch. The switch holds a control byte and three 256-byte memories: received channel data, and the low and high bytes of a per-channel connection entry. The processor sees all of it through a 6-bit address window. When the top address bit is clear, the access reaches the control byte. When it is set, the five low address bits pick one of 32 channels inside a page. The control byte chooses that page by naming a memory and a stream.

The bus strobes are brought into the clock domain by a synchronizer. A state machine then decodes each access and serves it. States: `ST_IDLE` waits for a strobe. `ST_CREG_RD` spends one cycle fetching the control byte. `ST_MEM_WAIT` holds a request toward the memory arrays until they grant it. `ST_ACK` drives the active-low acknowledge until the strobe is released.

Transitions:
- A control write goes `ST_IDLE` to `ST_ACK` directly.
- A control read goes `ST_IDLE` to `ST_CREG_RD` to `ST_ACK`.
- A memory access goes `ST_IDLE` to `ST_MEM_WAIT` to `ST_ACK`, leaving `ST_MEM_WAIT` on grant.
- A dropped write or a reserved read goes `ST_IDLE` to `ST_ACK`.
- `ST_ACK` returns to `ST_IDLE` when the synchronized strobe falls.

A split mode routes every memory read to the data memory and every memory write to the connection low byte. The split bit and a global processor-mode bit are exported to the rest of the switch.

Top module: `tsi_cpu_port`

## Requirements
- R1: After reset the control byte is 0x00, `cpu_ack_n` is 1, `mem_req` is 0, and `split_mode` and `proc_mode` are 0.
- R2: An access with `cpu_addr[5]`=0 writes or reads the control byte, whatever `cpu_addr[4:0]` holds. Bit 5 is not stored and always reads back as 0.
- R3: A control-byte write is acknowledged SYNC_STAGES+1 clock cycles after the strobe becomes active, and it raises no memory request.
- R4: A control-byte read is acknowledged one cycle later than a control-byte write. It returns the stored byte.
- R5: When `cpu_addr[5]`=1 and split mode is off, `mem_addr` = {control[2:0], `cpu_addr[4:0]`} and `mem_sel` = control[4:3]. The encodings are: 01 data memory, 10 connection low byte, 11 connection high byte, 00 reserved.
- R6: A memory access holds `mem_req` high, with a stable address, until `mem_gnt`. Acknowledge follows only after the grant. A read returns `mem_rdata` as sampled with the grant.
- R7: Once asserted, acknowledge stays low while the strobe (`cpu_cs_n`=0 and `cpu_ds`=1) is held. It returns high within SYNC_STAGES+1 cycles of release. `mem_req` is never high while acknowledge is low.
- R8: A write whose selection is the data memory (01) or reserved (00) is acknowledged, raises no request, and leaves memory contents unchanged.
- R9: A read whose selection is reserved (00) returns 0x00 without a memory request.
- R10: With control bit 7 set, memory reads use selection 01 and memory writes use selection 10, whatever control[4:3] holds. The stream field still picks the page.
- R11: `split_mode` follows control bit 7 and `proc_mode` follows control bit 6.
- R12: `mem_we` is 1 for writes (`cpu_rd_wr`=0) and 0 for reads. `mem_wdata` carries the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_cs_n | input | 1 | Chip select, active low |
| cpu_ds | input | 1 | Data strobe, active high |
| cpu_rd_wr | input | 1 | 1 = read, 0 = write |
| cpu_addr | input | 6 | Window address: bit 5 picks memory page, bits 4:0 channel |
| cpu_wdata | input | 8 | Write data from the processor |
| cpu_rdata | output | 8 | Read data toward the processor |
| cpu_rdata_oe | output | 1 | Drive enable for the read data bus |
| cpu_ack_n | output | 1 | Transfer-complete acknowledge, active low |
| mem_req | output | 1 | Request toward the memory arrays |
| mem_gnt | input | 1 | Grant from the memory arrays |
| mem_we | output | 1 | 1 = write request |
| mem_sel | output | 2 | Memory selection of the request |
| mem_addr | output | 8 | {stream, channel} location |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid with grant |
| split_mode | output | 1 | Split read/write routing active |
| proc_mode | output | 1 | Global processor-mode flag |

## Verification
A machine stuck outside `ST_IDLE`, or one that re-enters it early, shows at `cpu_ack_n` within one access. The acknowledge may never fall, may fall before `mem_gnt`, or may rise while the strobe is still held. A corrupted control byte shows at the memory side on the next paged access, as a wrong `mem_sel` or wrong `mem_addr` upper bits. It also shows at `cpu_rdata` on the next control read. Wrong split routing becomes visible when a later access reads back from a different memory than the one that was written.

// File: rtl/tsi_port_pkg.sv
package tsi_port_pkg;
    localparam int BYTE_W   = 8;
    localparam int STREAM_W = 3;
    localparam int CHAN_W   = 5;
    localparam int WIN_W    = CHAN_W + 1;
    localparam int LOC_W    = STREAM_W + CHAN_W;

    typedef enum logic [1:0] {
        SEL_RSVD = 2'b00,
        SEL_DATA = 2'b01,
        SEL_CLO  = 2'b10,
        SEL_CHI  = 2'b11
    } mem_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CREG_RD,
        ST_MEM_WAIT,
        ST_ACK
    } port_state_e;

    typedef struct packed {
        logic                split;
        logic                proc;
        logic                spare;
        mem_sel_e            sel;
        logic [STREAM_W-1:0] stream;
    } ctrl_t;
endpackage

// File: rtl/tsi_port_sync.sv
module tsi_port_sync #(
    parameter int          STAGES    = 2,
    parameter int          WIDTH     = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= RESET_VAL;
        end else begin
            chain_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/tsi_ctrl_reg.sv
module tsi_ctrl_reg
    import tsi_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output ctrl_t             ctrl_q
);
    ctrl_t next_val;

    always_comb begin
        next_val       = ctrl_t'(wr_data);
        next_val.spare = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ctrl_q <= '0;
        else if (wr_en) ctrl_q <= next_val;
    end
endmodule

// File: rtl/tsi_page_decode.sv
module tsi_page_decode
    import tsi_port_pkg::*;
(
    input  logic                split,
    input  mem_sel_e            sel_field,
    input  logic [STREAM_W-1:0] stream,
    input  logic [CHAN_W-1:0]   chan,
    input  logic                is_read,
    output mem_sel_e            eff_sel,
    output logic [LOC_W-1:0]    page_addr,
    output logic                drop_wr,
    output logic                null_rd
);
    always_comb begin
        if (split) eff_sel = is_read ? SEL_DATA : SEL_CLO;
        else       eff_sel = sel_field;
        page_addr = {stream, chan};
        drop_wr   = !is_read && (eff_sel == SEL_DATA || eff_sel == SEL_RSVD);
        null_rd   = is_read && (eff_sel == SEL_RSVD);
    end
endmodule

// File: rtl/tsi_port_fsm.sv
module tsi_port_fsm
    import tsi_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              rd_wr,
    input  logic              page_hit,
    input  logic [BYTE_W-1:0] wdata,
    input  mem_sel_e          dec_sel,
    input  logic [LOC_W-1:0]  dec_addr,
    input  logic              dec_drop,
    input  logic              dec_null,
    input  logic [BYTE_W-1:0] ctrl_byte,
    input  logic              mem_gnt,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              creg_we,
    output logic              ack_n,
    output logic              drive_en,
    output logic              mem_req,
    output logic              mem_we,
    output mem_sel_e          mem_sel,
    output logic [LOC_W-1:0]  mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic [BYTE_W-1:0] rdata
);
    port_state_e state_q, state_d;
    logic              rd_q;
    mem_sel_e          sel_q;
    logic [LOC_W-1:0]  addr_q;
    logic [BYTE_W-1:0] wdata_q;
    logic [BYTE_W-1:0] rdata_q;
    logic              start;

    assign start = (state_q == ST_IDLE) && strobe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (strobe) begin
                    if (!page_hit)                 state_d = rd_wr ? ST_CREG_RD : ST_ACK;
                    else if (dec_drop || dec_null) state_d = ST_ACK;
                    else                           state_d = ST_MEM_WAIT;
                end
            end
            ST_CREG_RD:  state_d = ST_ACK;
            ST_MEM_WAIT: if (mem_gnt) state_d = ST_ACK;
            ST_ACK:      if (!strobe) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q    <= 1'b0;
            sel_q   <= SEL_RSVD;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (start) begin
                rd_q    <= rd_wr;
                sel_q   <= dec_sel;
                addr_q  <= dec_addr;
                wdata_q <= wdata;
                if (page_hit && dec_null) rdata_q <= '0;
            end
            if (state_q == ST_CREG_RD) rdata_q <= ctrl_byte;
            if (state_q == ST_MEM_WAIT && mem_gnt && rd_q) rdata_q <= mem_rdata;
        end
    end

    always_comb begin
        creg_we   = start && !page_hit && !rd_wr;
        ack_n     = (state_q != ST_ACK);
        drive_en  = (state_q == ST_ACK) && rd_q;
        mem_req   = (state_q == ST_MEM_WAIT);
        mem_we    = !rd_q;
        mem_sel   = sel_q;
        mem_addr  = addr_q;
        mem_wdata = wdata_q;
        rdata     = rdata_q;
    end
endmodule

// File: rtl/tsi_cpu_port.sv
module tsi_cpu_port
    import tsi_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_cs_n,
    input  logic        cpu_ds,
    input  logic        cpu_rd_wr,
    input  logic [5:0]  cpu_addr,
    input  logic [7:0]  cpu_wdata,
    output logic [7:0]  cpu_rdata,
    output logic        cpu_rdata_oe,
    output logic        cpu_ack_n,
    output logic        mem_req,
    input  logic        mem_gnt,
    output logic        mem_we,
    output logic [1:0]  mem_sel,
    output logic [7:0]  mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata,
    output logic        split_mode,
    output logic        proc_mode
);
    logic [1:0] bus_s;
    logic       strobe_s;
    ctrl_t      ctrl_q;
    mem_sel_e   dec_sel, fsm_sel;
    logic [LOC_W-1:0] dec_addr;
    logic       dec_drop, dec_null, creg_we;

    tsi_port_sync #(.STAGES(SYNC_STAGES), .WIDTH(2), .RESET_VAL(2'b10)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_in({cpu_cs_n, cpu_ds}), .sync_out(bus_s)
    );

    assign strobe_s = !bus_s[1] && bus_s[0];

    tsi_ctrl_reg u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(creg_we),
        .wr_data(cpu_wdata), .ctrl_q(ctrl_q)
    );

    tsi_page_decode u_dec (
        .split(ctrl_q.split), .sel_field(ctrl_q.sel), .stream(ctrl_q.stream),
        .chan(cpu_addr[CHAN_W-1:0]), .is_read(cpu_rd_wr),
        .eff_sel(dec_sel), .page_addr(dec_addr),
        .drop_wr(dec_drop), .null_rd(dec_null)
    );

    tsi_port_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .strobe(strobe_s), .rd_wr(cpu_rd_wr),
        .page_hit(cpu_addr[WIN_W-1]), .wdata(cpu_wdata),
        .dec_sel(dec_sel), .dec_addr(dec_addr), .dec_drop(dec_drop), .dec_null(dec_null),
        .ctrl_byte(ctrl_q), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .creg_we(creg_we), .ack_n(cpu_ack_n), .drive_en(cpu_rdata_oe),
        .mem_req(mem_req), .mem_we(mem_we), .mem_sel(fsm_sel),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rdata(cpu_rdata)
    );

    assign mem_sel    = fsm_sel;
    assign split_mode = ctrl_q.split;
    assign proc_mode  = ctrl_q.proc;
endmodule

// File: rtl/tsi_port_chk.sv
module tsi_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ack_n,
    input logic       strobe_s,
    input logic       mem_req,
    input logic       mem_gnt,
    input logic       mem_we,
    input logic [1:0] mem_sel,
    input logic [7:0] mem_addr,
    input logic       split_mode
);
    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

    p_ack_after_gnt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ack_n) && $past(mem_req)) |-> $past(mem_gnt));

    p_ack_no_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |-> !mem_req);

    p_ack_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && strobe_s) |=> !ack_n);

    p_no_dm_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_sel == 2'b10 || mem_sel == 2'b11));

    p_no_rsvd_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_sel != 2'b00));

    p_split_route_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && split_mode) |-> (mem_we ? (mem_sel == 2'b10) : (mem_sel == 2'b01)));
endmodule

bind tsi_cpu_port tsi_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ack_n(cpu_ack_n), .strobe_s(strobe_s),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we),
    .mem_sel(mem_sel), .mem_addr(mem_addr), .split_mode(split_mode)
);

// File: tb/tb_tsi_cpu_port.sv
`timescale 1ns/1ps
module tb_tsi_cpu_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_cs_n = 1'b1, cpu_ds = 1'b0, cpu_rd_wr = 1'b1;
    logic [5:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       cpu_rdata_oe, cpu_ack_n;
    logic       mem_req, mem_we, split_mode, proc_mode;
    logic       mem_gnt = 1'b0;
    logic [1:0] mem_sel;
    logic [7:0] mem_addr, mem_wdata;
    logic [7:0] mem_rdata = '0;

    int checks = 0, errors = 0;
    int gnt_delay = 0, req_cycles = 0;
    logic [7:0] bmem [4][256];

    always #2.5 clk = ~clk;

    tsi_cpu_port #(.SYNC_STAGES(2)) dut (.*);

    function automatic logic [7:0] pat(int s, int a);
        return 8'((a * 7 + s * 61) ^ 8'h5A);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // memory model: grant after gnt_delay request cycles
    initial begin
        int cnt = 0;
        for (int s = 0; s < 4; s++) for (int a = 0; a < 256; a++) bmem[s][a] = pat(s, a);
        forever begin
            @(negedge clk);
            if (mem_gnt) begin
                mem_gnt = 1'b0; cnt = 0;
            end else if (mem_req) begin
                req_cycles++;
                if (cnt >= gnt_delay) begin
                    mem_gnt   = 1'b1;
                    mem_rdata = bmem[mem_sel][mem_addr];
                    if (mem_we) bmem[mem_sel][mem_addr] = mem_wdata;
                end else cnt++;
            end
        end
    end

    task automatic access(input bit rd, input logic [5:0] a, input logic [7:0] d,
                          input int hold, output logic [7:0] q, output int lat, output int rel);
        @(negedge clk);
        cpu_rd_wr = rd; cpu_addr = a; cpu_wdata = d;
        cpu_cs_n = 1'b0; cpu_ds = 1'b1;
        lat = 0;
        do begin @(negedge clk); lat++; end while (cpu_ack_n && lat < 60);
        q = cpu_rdata;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk(!cpu_ack_n, "R7 hold", cpu_ack_n, 0);
        end
        cpu_ds = 1'b0; cpu_cs_n = 1'b1;
        rel = 0;
        do begin @(negedge clk); rel++; end while (!cpu_ack_n && rel < 60);
    endtask

    typedef struct packed {
        logic       rd;
        logic [5:0] a;
        logic [7:0] d;
        logic [7:0] exp;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{1'b0, 6'h00, 8'h13, 8'h00},
        '{1'b0, 6'h25, 8'hA5, 8'h00},
        '{1'b1, 6'h25, 8'h00, 8'hA5},
        '{1'b0, 6'h1F, 8'h1B, 8'h00},
        '{1'b0, 6'h25, 8'h5C, 8'h00},
        '{1'b1, 6'h25, 8'h00, 8'h5C},
        '{1'b1, 6'h07, 8'h00, 8'h1B},
        '{1'b0, 6'h00, 8'h33, 8'h00},
        '{1'b1, 6'h00, 8'h00, 8'h13},
        '{1'b1, 6'h25, 8'h00, 8'hA5}
    };

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] q;
        int lat, rel, rq0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cpu_ack_n == 1'b1, "R1 ack", cpu_ack_n, 1);
        chk(mem_req == 1'b0, "R1 req", mem_req, 0);
        chk(split_mode == 1'b0 && proc_mode == 1'b0, "R1 flags", {split_mode, proc_mode}, 0);
        rst_n = 1'b1;
        access(1, 6'h00, 8'h00, 0, q, lat, rel);
        chk(q == 8'h00, "R1 ctrl reset", q, 0);

        // vector walk: R2 R5 R12
        foreach (VECS[i]) begin
            access(VECS[i].rd, VECS[i].a, VECS[i].d, 0, q, lat, rel);
            chk(lat < 60, "R2/R5 ack seen", lat, 0);
            if (VECS[i].rd) chk(q == VECS[i].exp, "R2/R5/R12 readback", q, VECS[i].exp);
        end

        // R3 / R4 latency
        rq0 = req_cycles;
        access(0, 6'h0A, 8'h13, 0, q, lat, rel);
        chk(lat == 3, "R3 write latency", lat, 3);
        chk(req_cycles == rq0, "R3 no request", req_cycles - rq0, 0);
        access(1, 6'h00, 8'h00, 0, q, lat, rel);
        chk(lat == 4, "R4 read latency", lat, 4);
        chk(q == 8'h13, "R4 read value", q, 8'h13);

        // R6 slow grant, R5 address/select, R12 direction
        gnt_delay = 5;
        fork
            access(1, 6'h2C, 8'h00, 0, q, lat, rel);
            begin
                repeat (5) @(negedge clk);
                chk(mem_req && cpu_ack_n, "R6 wait before grant", {mem_req, cpu_ack_n}, 3);
                chk(mem_addr == 8'h6C, "R5 page address", mem_addr, 8'h6C);
                chk(mem_sel == 2'b10, "R5 select", mem_sel, 2);
                chk(mem_we == 1'b0, "R12 read direction", mem_we, 0);
            end
        join
        chk(lat == 9, "R6 ack after grant", lat, 9);
        chk(q == pat(2, 8'h6C), "R6 read data", q, pat(2, 8'h6C));
        gnt_delay = 0;

        // R7 long hold and release
        access(0, 6'h00, 8'h13, 10, q, lat, rel);
        chk(rel <= 3, "R7 release", rel, 3);

        // R8 writes to data memory and reserved selection
        access(0, 6'h00, 8'h0B, 0, q, lat, rel);
        rq0 = req_cycles;
        access(0, 6'h25, 8'hEE, 0, q, lat, rel);
        chk(lat < 60 && req_cycles == rq0, "R8 data write dropped", req_cycles - rq0, 0);
        access(1, 6'h25, 8'h00, 0, q, lat, rel);
        chk(q == pat(1, 8'h65), "R8 data memory unchanged", q, pat(1, 8'h65));
        access(0, 6'h00, 8'h03, 0, q, lat, rel);
        rq0 = req_cycles;
        access(0, 6'h25, 8'hEE, 0, q, lat, rel);
        chk(lat < 60 && req_cycles == rq0, "R8 reserved write dropped", req_cycles - rq0, 0);
        // R9 reserved read
        access(1, 6'h25, 8'h00, 0, q, lat, rel);
        chk(q == 8'h00 && req_cycles == rq0, "R9 reserved read", q, 0);

        // R10 split mode: write to conn low, read from data memory
        access(0, 6'h00, 8'h9B, 0, q, lat, rel);
        chk(split_mode == 1'b1, "R11 split flag", split_mode, 1);
        access(0, 6'h26, 8'h77, 0, q, lat, rel);
        access(1, 6'h26, 8'h00, 0, q, lat, rel);
        chk(q == pat(1, 8'h66), "R10 split read data memory", q, pat(1, 8'h66));
        access(0, 6'h00, 8'h13, 0, q, lat, rel);
        access(1, 6'h26, 8'h00, 0, q, lat, rel);
        chk(q == 8'h77, "R10 split write to conn low", q, 8'h77);
        access(0, 6'h00, 8'h1B, 0, q, lat, rel);
        access(1, 6'h26, 8'h00, 0, q, lat, rel);
        chk(q == pat(3, 8'h66), "R10 conn high untouched", q, pat(3, 8'h66));

        // R11 flag outputs
        access(0, 6'h00, 8'hC0, 0, q, lat, rel);
        chk(split_mode && proc_mode, "R11 both flags", {split_mode, proc_mode}, 3);
        access(0, 6'h00, 8'h40, 0, q, lat, rel);
        chk(!split_mode && proc_mode, "R11 proc only", {split_mode, proc_mode}, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule